// File: doc/BRIEF.md
# Processor System Register File

This block holds the control registers of a 32-bit processor core. It also holds the program counter. A 5-bit index selects one of 32 register slots. The read port returns the selected slot combinationally. A write takes effect on the next rising clock edge. The debug qualifier lifts the restrictions that apply to ordinary writes.

Each slot has its own write and read behaviour:
- Some slots drop low-order bits when written.
- Some keep only a field mask.
- Some return fixed identification constants and never change.
- The cause register changes only under debug.
- One scratch slot keeps the absolute value of what an ordinary write supplies.

The ALU's four condition flags load into the status word every cycle that it asks. The one exception is a cycle in which software writes the status word itself. A synchronous reset loads the architectural start-up values.

Top module: `sysreg_file`

## Requirements
- R1: While `rst` is high at a rising edge, every register clears, with three exceptions. `pc_o` becomes 0xFFFFFFF0. Status (index 5) reads 0x00008000, which is only the NP bit (bit 15). Cause (index 4) reads 0x0000FFF0.
- R2: The two exception-PC slots (index 0 and 2) and the address-trap slot (index 25) store the written data with bit 0 forced to 0.
- R3: The two saved-status slots (index 1 and 3) store only the written bits under mask 0x000FF3FF.
- R4: The status slot (index 5) stores the written data under mask 0x000FF3FF. Its fields are:
  - Z at bit 0, S at bit 1, OV at bit 2, CY at bit 3
  - floating flags at bits 9:4
  - ID, AE, EP and NP at bits 12 to 15
  - the interrupt level at bits 19:16
- R5: When `flag_we` is high and the same cycle does not write index 5, bits 3:0 of the status word become {cy, ov, s, z} at that edge. A write to index 5 in the same cycle wins over the flags.
- R6: Index 6 always reads 0x00005346, index 7 always reads 0x000000E0 and index 30 always reads 0x00000004. Writes to these slots have no effect.
- R7: The cause slot (index 4) holds the fatal cause in bits 31:16 and the exception cause in bits 15:0. Only a write with `wr_dbg` high changes it, and such a write stores all 32 bits.
- R8: The cache-control slot (index 24) reads back only bit 1 of its last written value, in bit 1. All other bits read 0.
- R9: A write to index 31 with `wr_dbg` low stores the two's-complement absolute value of the data; 0x80000000 stays 0x80000000. With `wr_dbg` high it stores the data unchanged.
- R10: Index 29 is a plain 32-bit read/write register.
- R11: Indices 8 to 23 and 26 to 28 always read 0 and ignore writes.
- R12: When `pc_we` is high and `rst` is low, `pc_o` takes `pc_nxt` at that edge.
- R13: When `wr_en` is low, no write occurs, whatever the other write inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| idx | input | 5 | Register index for both read and write |
| wr_en | input | 1 | Write strobe |
| wr_dbg | input | 1 | Qualifies the write as a debug access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read value of the slot at `idx` |
| flag_we | input | 1 | Load the ALU condition flags |
| flag_z | input | 1 | Zero flag from the ALU |
| flag_s | input | 1 | Sign flag from the ALU |
| flag_ov | input | 1 | Overflow flag from the ALU |
| flag_cy | input | 1 | Carry flag from the ALU |
| pc_we | input | 1 | Load the program counter |
| pc_nxt | input | 32 | Next program counter value |
| pc_o | output | 32 | Current program counter |

## Verification
The bench builds the block with its default parameters:
- reset PC 0xFFFFFFF0
- reset exception cause 0xFFF0
- identification constants 0x5346, 0xE0 and 0x4

With those values, the expected numbers in the requirements can be compared bit for bit. At these defaults, the table reaches every masking rule, including the full-ones write against each mask. It also reaches the negative, positive and most-negative inputs to the absolute-value slot. Finally, it covers the flag path colliding with a status write in the same cycle.

// File: rtl/sysreg_file.sv
module sysreg_file #(
  parameter logic [31:0] RESET_PC    = 32'hFFFF_FFF0,
  parameter logic [15:0] RESET_CAUSE = 16'hFFF0,
  parameter logic [31:0] CPU_ID      = 32'h0000_5346,
  parameter logic [31:0] TASK_CTRL   = 32'h0000_00E0,
  parameter logic [31:0] SLOT30_VAL  = 32'h0000_0004
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [4:0]  idx,
  input  logic        wr_en,
  input  logic        wr_dbg,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        flag_we,
  input  logic        flag_z,
  input  logic        flag_s,
  input  logic        flag_ov,
  input  logic        flag_cy,
  input  logic        pc_we,
  input  logic [31:0] pc_nxt,
  output logic [31:0] pc_o
);
  localparam logic [4:0] IX_EPC   = 5'd0;
  localparam logic [4:0] IX_EST   = 5'd1;
  localparam logic [4:0] IX_FPC   = 5'd2;
  localparam logic [4:0] IX_FST   = 5'd3;
  localparam logic [4:0] IX_CAUSE = 5'd4;
  localparam logic [4:0] IX_STAT  = 5'd5;
  localparam logic [4:0] IX_ID    = 5'd6;
  localparam logic [4:0] IX_TASK  = 5'd7;
  localparam logic [4:0] IX_CACHE = 5'd24;
  localparam logic [4:0] IX_TRAP  = 5'd25;
  localparam logic [4:0] IX_SCR   = 5'd29;
  localparam logic [4:0] IX_C30   = 5'd30;
  localparam logic [4:0] IX_ABS   = 5'd31;

  localparam logic [31:0] ST_MASK  = 32'h000F_F3FF;
  localparam logic [31:0] PC_MASK  = 32'hFFFF_FFFE;
  localparam logic [31:0] ST_RESET = 32'h0000_8000;
  localparam int          ICE_BIT  = 1;

  logic [31:0] epc_q, est_q, fpc_q, fst_q, cause_q, stat_q;
  logic [31:0] trap_q, scr_q, abs_q, pc_q;
  logic        ice_q;

  logic [31:0] wd_even, wd_st, wd_abs;
  logic        stat_wr;

  assign wd_even = wr_data & PC_MASK;
  assign wd_st   = wr_data & ST_MASK;
  assign wd_abs  = (wr_dbg || !wr_data[31]) ? wr_data : (~wr_data + 32'd1);
  assign stat_wr = wr_en && (idx == IX_STAT);
  assign pc_o    = pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      epc_q   <= '0;
      est_q   <= '0;
      fpc_q   <= '0;
      fst_q   <= '0;
      cause_q <= {16'h0000, RESET_CAUSE};
      stat_q  <= ST_RESET;
      trap_q  <= '0;
      scr_q   <= '0;
      abs_q   <= '0;
      ice_q   <= 1'b0;
    end else begin
      if (wr_en) begin
        case (idx)
          IX_EPC:   epc_q  <= wd_even;
          IX_EST:   est_q  <= wd_st;
          IX_FPC:   fpc_q  <= wd_even;
          IX_FST:   fst_q  <= wd_st;
          IX_CAUSE: if (wr_dbg) cause_q <= wr_data;
          IX_CACHE: ice_q  <= wr_data[ICE_BIT];
          IX_TRAP:  trap_q <= wd_even;
          IX_SCR:   scr_q  <= wr_data;
          IX_ABS:   abs_q  <= wd_abs;
          default: ;
        endcase
      end
      if (stat_wr)
        stat_q <= wd_st;
      else if (flag_we)
        stat_q[3:0] <= {flag_cy, flag_ov, flag_s, flag_z};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        pc_q <= RESET_PC;
    else if (pc_we) pc_q <= pc_nxt;
  end

  always_comb begin
    case (idx)
      IX_EPC:   rd_data = epc_q;
      IX_EST:   rd_data = est_q;
      IX_FPC:   rd_data = fpc_q;
      IX_FST:   rd_data = fst_q;
      IX_CAUSE: rd_data = cause_q;
      IX_STAT:  rd_data = stat_q;
      IX_ID:    rd_data = CPU_ID;
      IX_TASK:  rd_data = TASK_CTRL;
      IX_CACHE: rd_data = 32'(ice_q) << ICE_BIT;
      IX_TRAP:  rd_data = trap_q;
      IX_SCR:   rd_data = scr_q;
      IX_C30:   rd_data = SLOT30_VAL;
      IX_ABS:   rd_data = abs_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

module sysreg_file_chk (
  input logic        clk,
  input logic        rst,
  input logic [4:0]  idx,
  input logic        wr_en,
  input logic        wr_dbg,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        flag_we,
  input logic        flag_z,
  input logic        flag_s,
  input logic        flag_ov,
  input logic        flag_cy,
  input logic        pc_we,
  input logic [31:0] pc_nxt,
  input logic [31:0] pc_o,
  input logic [31:0] epc_q,
  input logic [31:0] cause_q,
  input logic [31:0] stat_q
);
  a_r1_reset_pc: assert property (@(posedge clk) rst |=> pc_o == 32'hFFFF_FFF0);

  a_r2_even_pc: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == 5'd0) |=> epc_q == ($past(wr_data) & 32'hFFFF_FFFE));

  a_r5_flags: assert property (@(posedge clk) disable iff (rst)
    (flag_we && !(wr_en && idx == 5'd5)) |=>
      stat_q[3:0] == $past({flag_cy, flag_ov, flag_s, flag_z}));

  a_r6_cpu_id: assert property (@(posedge clk) disable iff (rst)
    idx == 5'd6 |-> rd_data == 32'h0000_5346);

  a_r7_cause_guard: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_dbg && idx == 5'd4) |=> $stable(cause_q));

  a_r11_unused_zero: assert property (@(posedge clk) disable iff (rst)
    ((idx >= 5'd8 && idx <= 5'd23) || (idx >= 5'd26 && idx <= 5'd28)) |-> rd_data == 32'h0);

  a_r12_pc_load: assert property (@(posedge clk) disable iff (rst)
    pc_we |=> pc_o == $past(pc_nxt));
endmodule

bind sysreg_file sysreg_file_chk u_chk (
  .clk(clk), .rst(rst), .idx(idx), .wr_en(wr_en), .wr_dbg(wr_dbg),
  .wr_data(wr_data), .rd_data(rd_data), .flag_we(flag_we), .flag_z(flag_z),
  .flag_s(flag_s), .flag_ov(flag_ov), .flag_cy(flag_cy), .pc_we(pc_we),
  .pc_nxt(pc_nxt), .pc_o(pc_o), .epc_q(epc_q), .cause_q(cause_q), .stat_q(stat_q)
);

// File: tb/sim_sysreg_file.sv
`timescale 1ns/100ps
module sim_sysreg_file;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  idx = '0;
  logic        wr_en = 1'b0, wr_dbg = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        flag_we = 1'b0, flag_z = 1'b0, flag_s = 1'b0, flag_ov = 1'b0, flag_cy = 1'b0;
  logic        pc_we = 1'b0;
  logic [31:0] pc_nxt = '0;
  logic [31:0] pc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sysreg_file u0 (
    .clk(clk), .rst(rst), .idx(idx), .wr_en(wr_en), .wr_dbg(wr_dbg),
    .wr_data(wr_data), .rd_data(rd_data), .flag_we(flag_we), .flag_z(flag_z),
    .flag_s(flag_s), .flag_ov(flag_ov), .flag_cy(flag_cy), .pc_we(pc_we),
    .pc_nxt(pc_nxt), .pc_o(pc_o)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        dbg;
    logic [4:0]  ix;
    logic [31:0] wd;
    logic [31:0] ex;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{4'd2,  1'b0, 5'd0,  32'h1234_5677, 32'h1234_5676}, // R2
    '{4'd2,  1'b0, 5'd2,  32'hFFFF_FFFF, 32'hFFFF_FFFE}, // R2
    '{4'd2,  1'b0, 5'd25, 32'h0000_0003, 32'h0000_0002}, // R2
    '{4'd3,  1'b0, 5'd1,  32'hFFFF_FFFF, 32'h000F_F3FF}, // R3
    '{4'd3,  1'b0, 5'd3,  32'hA5A5_A5A5, 32'h0005_A1A5}, // R3
    '{4'd4,  1'b0, 5'd5,  32'hFFFF_FFFF, 32'h000F_F3FF}, // R4
    '{4'd4,  1'b0, 5'd5,  32'h0003_0005, 32'h0003_0005}, // R4
    '{4'd6,  1'b0, 5'd6,  32'hFFFF_FFFF, 32'h0000_5346}, // R6
    '{4'd6,  1'b1, 5'd7,  32'h0000_0000, 32'h0000_00E0}, // R6
    '{4'd6,  1'b0, 5'd30, 32'hFFFF_FFFF, 32'h0000_0004}, // R6
    '{4'd7,  1'b0, 5'd4,  32'h1234_5678, 32'h0000_FFF0}, // R7
    '{4'd7,  1'b1, 5'd4,  32'hDEAD_BEEF, 32'hDEAD_BEEF}, // R7
    '{4'd8,  1'b0, 5'd24, 32'hFFFF_FFFF, 32'h0000_0002}, // R8
    '{4'd8,  1'b0, 5'd24, 32'hFFFF_FFFD, 32'h0000_0000}, // R8
    '{4'd9,  1'b0, 5'd31, 32'hFFFF_FFFE, 32'h0000_0002}, // R9
    '{4'd9,  1'b1, 5'd31, 32'hFFFF_FFFE, 32'hFFFF_FFFE}, // R9
    '{4'd9,  1'b0, 5'd31, 32'h8000_0000, 32'h8000_0000}, // R9
    '{4'd10, 1'b0, 5'd29, 32'hCAFE_F00D, 32'hCAFE_F00D}, // R10
    '{4'd11, 1'b1, 5'd8,  32'hFFFF_FFFF, 32'h0000_0000}, // R11
    '{4'd11, 1'b0, 5'd23, 32'hFFFF_FFFF, 32'h0000_0000}, // R11
    '{4'd11, 1'b1, 5'd27, 32'hFFFF_FFFF, 32'h0000_0000}  // R11
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] i, input logic [31:0] d, input logic dbg);
    @(negedge clk);
    idx = i; wr_data = d; wr_dbg = dbg; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_dbg = 1'b0;
  endtask

  task automatic rd_check(input string rq, input logic [4:0] i, input logic [31:0] exp);
    idx = i;
    #1;
    check(rq, rd_data, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    do_reset();
    // R1 reset state
    check("R1", pc_o, 32'hFFFF_FFF0);
    rd_check("R1", 5'd5, 32'h0000_8000);
    rd_check("R1", 5'd4, 32'h0000_FFF0);
    rd_check("R1", 5'd0, 32'h0);
    rd_check("R1", 5'd29, 32'h0);
    rd_check("R1", 5'd31, 32'h0);
    rd_check("R1", 5'd24, 32'h0);

    for (int k = 0; k < NV; k++) begin
      wr(VEC[k].ix, VEC[k].wd, VEC[k].dbg);
      rd_check($sformatf("R%0d vec%0d", VEC[k].req, k), VEC[k].ix, VEC[k].ex);
    end

    // R9 positive value via ordinary write
    wr(5'd31, 32'h0000_0007, 1'b0);
    rd_check("R9", 5'd31, 32'h0000_0007);

    // R13 no write without strobe
    @(negedge clk);
    idx = 5'd29; wr_data = 32'h1111_2222; wr_dbg = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    wr_dbg = 1'b0;
    rd_check("R13", 5'd29, 32'hCAFE_F00D);

    // R5 flag load while status not written
    wr(5'd5, 32'h0000_0000, 1'b0);
    @(negedge clk);
    flag_we = 1'b1; flag_z = 1'b1; flag_s = 1'b0; flag_ov = 1'b1; flag_cy = 1'b1;
    idx = 5'd29; wr_en = 1'b1; wr_data = 32'h0000_0055;
    @(negedge clk);
    flag_we = 1'b0; wr_en = 1'b0;
    rd_check("R5", 5'd5, 32'h0000_000D);
    rd_check("R10", 5'd29, 32'h0000_0055);

    // R5 status write wins over flags in same cycle
    @(negedge clk);
    flag_we = 1'b1; flag_z = 1'b1; flag_s = 1'b1; flag_ov = 1'b1; flag_cy = 1'b1;
    idx = 5'd5; wr_en = 1'b1; wr_data = 32'h0000_1000;
    @(negedge clk);
    flag_we = 1'b0; wr_en = 1'b0;
    rd_check("R5", 5'd5, 32'h0000_1000);

    // R12 PC load
    @(negedge clk);
    pc_we = 1'b1; pc_nxt = 32'h0700_0100;
    @(negedge clk);
    pc_we = 1'b0;
    check("R12", pc_o, 32'h0700_0100);

    // R1 reset after activity
    do_reset();
    check("R1", pc_o, 32'hFFFF_FFF0);
    rd_check("R1", 5'd4, 32'h0000_FFF0);
    rd_check("R1", 5'd5, 32'h0000_8000);
    rd_check("R1", 5'd25, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule